// File: doc/BRIEF.md
# Memory-Mapped Pin Controller with Interrupts

This block is a general-purpose pin controller for up to 32 pins, configured through a 32-bit register file on a simple APB-style slave port. Each pin can be driven from a software-owned output value, read back through an input register, or handed to an alternate-function path. A per-pin handover bit selects the alternate path; when it is set, the pad follows the alternate function's data and enable signals.

Every pin can raise an interrupt. The trigger can be a level of either polarity, a rising edge, a falling edge, or both edges. Events are recorded in a status register whether or not the pin is masked. Reading that status register returns every recorded event and clears all of them in the same access; there is no separate acknowledge register. A single interrupt output signals the host whenever an unmasked status bit is set.

Pad inputs pass through a two-flop synchroniser before they reach the input register and the interrupt logic. The asynchronous active-low reset is released synchronously inside the block.

Top module: `gpio_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 handover, 0x04 direction, 0x08 output enable, 0x0C output value, 0x10 input value, 0x14 mask, 0x18 unmask-set, 0x1C mask-set, 0x20 status, 0x24 trigger type, 0x28 trigger polarity, 0x2C both-edges. Address bits [1:0] are ignored. Any other word reads as zero, and the two write-one registers also read as zero.
- R2: The pin count NPINS is a parameter from 1 to 32. Register bits at NPINS and above read as zero, and writes to them are dropped.
- R3: When a pin's handover bit is 0, pad_out follows the output value bit. pad_oe is 1 only when the direction bit is 0 (output) and the output enable bit is 1. The output value register reads back the last value written.
- R4: When a pin's handover bit is 1, pad_out equals alt_out and pad_oe equals alt_oe. alt_in always equals pad_in.
- R5: Writing 1s to the unmask-set word clears those mask bits, and writing 1s to the mask-set word sets them. Bits written as 0 leave the mask unchanged. The mask word reads back the mask, where 1 means masked.
- R6: The input value word returns pad_in after a two-flop synchroniser. A pad change is visible no later than three clock edges after it happens.
- R7: A status read returns all recorded events and clears every status bit at the end of that access.
- R8: With trigger type 1 (level), polarity 1 means active-high and 0 means active-low. A level that is still active sets its status bit again on the cycle after the clearing read.
- R9: With trigger type 0 (edge), polarity 1 selects rising edges and 0 selects falling edges. When the both-edges bit is 1, both edges trigger whatever the polarity.
- R10: irq is 1 exactly when some status bit is set and the matching mask bit is 0.
- R11: After reset, handover, direction and mask are all ones (every pin an input and masked). Every other register is zero.
- R12: Status bits record events whether the pin is masked or not, and hold until a status read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output data |
| pad_oe | output | NPINS | Pad output enable |
| alt_out | input | NPINS | Alternate-function output data |
| alt_oe | input | NPINS | Alternate-function output enable |
| alt_in | output | NPINS | Pad input levels passed to the alternate function |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with NPINS = 5. Bits 5 to 31 of every register are therefore unimplemented and can be checked as read-zero and write-ignore. Five pins also keep the state space small enough to sweep all 1024 combinations of handover and direction against fixed output and alternate patterns. For the interrupt logic, the bench runs every pin through all six trigger settings, every start and end level, and both mask states. The expected status, irq and re-set level are computed from a small arithmetic model of each trigger.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned DATA_W     = 32;
  // word indices (byte offset / 4)
  localparam int unsigned REG_HANDOVER = 0;
  localparam int unsigned REG_DIR      = 1;
  localparam int unsigned REG_OEN      = 2;
  localparam int unsigned REG_OVAL     = 3;
  localparam int unsigned REG_INVAL    = 4;
  localparam int unsigned REG_MASK     = 5;
  localparam int unsigned REG_UNMASK   = 6;
  localparam int unsigned REG_SETMASK  = 7;
  localparam int unsigned REG_STATUS   = 8;
  localparam int unsigned REG_TTYPE    = 9;
  localparam int unsigned REG_TPOL     = 10;
  localparam int unsigned REG_TBOTH    = 11;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= 2'b00;
    end else begin
      chain_q <= {chain_q[0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] async_in,
  output logic [NPINS-1:0] sync_out
);
  logic [NPINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [NPINS-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_in;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] level_in,
  input  logic [NPINS-1:0] ttype,
  input  logic [NPINS-1:0] tpol,
  input  logic [NPINS-1:0] tboth,
  input  logic             clear_all,
  output logic [NPINS-1:0] status
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] stat_q;
  logic [NPINS-1:0] stat_d;
  logic [NPINS-1:0] hit;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic rise, fall, lvl_hit, edge_hit;
    assign rise     = level_in[g] & ~prev_q[g];
    assign fall     = ~level_in[g] & prev_q[g];
    assign lvl_hit  = tpol[g] ? level_in[g] : ~level_in[g];
    assign edge_hit = tboth[g] ? (rise | fall) : (tpol[g] ? rise : fall);
    assign hit[g]   = ttype[g] ? lvl_hit : edge_hit;
  end

  always_comb begin
    stat_d = stat_q;
    if (clear_all) begin
      stat_d = '0;
    end
    stat_d = stat_d | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= level_in;
      stat_q <= stat_d;
    end
  end

  assign status = stat_q;

  // R12: without a clearing read, no recorded bit is lost
  a_r12_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_all |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R7: a clearing read with no new event leaves status empty
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_all && (hit == '0)) |=> (stat_q == '0));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  word,
  input  logic [NPINS-1:0]  wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPINS-1:0]  in_val,
  input  logic [NPINS-1:0]  status,
  output logic [NPINS-1:0]  handover,
  output logic [NPINS-1:0]  dir,
  output logic [NPINS-1:0]  oen,
  output logic [NPINS-1:0]  oval,
  output logic [NPINS-1:0]  mask,
  output logic [NPINS-1:0]  ttype,
  output logic [NPINS-1:0]  tpol,
  output logic [NPINS-1:0]  tboth,
  output logic              clear_all
);
  logic [NPINS-1:0] hov_q, hov_d, dir_q, dir_d, oen_q, oen_d, oval_q, oval_d;
  logic [NPINS-1:0] mask_q, mask_d, tty_q, tty_d, tpl_q, tpl_d, tbo_q, tbo_d;
  logic [NPINS-1:0] rd_sel;

  always_comb begin
    hov_d  = hov_q;
    dir_d  = dir_q;
    oen_d  = oen_q;
    oval_d = oval_q;
    mask_d = mask_q;
    tty_d  = tty_q;
    tpl_d  = tpl_q;
    tbo_d  = tbo_q;
    if (wr_en) begin
      case (word)
        IDX_W'(REG_HANDOVER): hov_d  = wdata;
        IDX_W'(REG_DIR):      dir_d  = wdata;
        IDX_W'(REG_OEN):      oen_d  = wdata;
        IDX_W'(REG_OVAL):     oval_d = wdata;
        IDX_W'(REG_UNMASK):   mask_d = mask_q & ~wdata;
        IDX_W'(REG_SETMASK):  mask_d = mask_q | wdata;
        IDX_W'(REG_TTYPE):    tty_d  = wdata;
        IDX_W'(REG_TPOL):     tpl_d  = wdata;
        IDX_W'(REG_TBOTH):    tbo_d  = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hov_q  <= '1;
      dir_q  <= '1;
      mask_q <= '1;
      oen_q  <= '0;
      oval_q <= '0;
      tty_q  <= '0;
      tpl_q  <= '0;
      tbo_q  <= '0;
    end else begin
      hov_q  <= hov_d;
      dir_q  <= dir_d;
      mask_q <= mask_d;
      oen_q  <= oen_d;
      oval_q <= oval_d;
      tty_q  <= tty_d;
      tpl_q  <= tpl_d;
      tbo_q  <= tbo_d;
    end
  end

  always_comb begin
    case (word)
      IDX_W'(REG_HANDOVER): rd_sel = hov_q;
      IDX_W'(REG_DIR):      rd_sel = dir_q;
      IDX_W'(REG_OEN):      rd_sel = oen_q;
      IDX_W'(REG_OVAL):     rd_sel = oval_q;
      IDX_W'(REG_INVAL):    rd_sel = in_val;
      IDX_W'(REG_MASK):     rd_sel = mask_q;
      IDX_W'(REG_STATUS):   rd_sel = status;
      IDX_W'(REG_TTYPE):    rd_sel = tty_q;
      IDX_W'(REG_TPOL):     rd_sel = tpl_q;
      IDX_W'(REG_TBOTH):    rd_sel = tbo_q;
      default:              rd_sel = '0;
    endcase
    rdata = '0;
    rdata[NPINS-1:0] = rd_sel;
  end

  assign clear_all = rd_en && (word == IDX_W'(REG_STATUS));
  assign handover  = hov_q;
  assign dir       = dir_q;
  assign oen       = oen_q;
  assign oval      = oval_q;
  assign mask      = mask_q;
  assign ttype     = tty_q;
  assign tpol      = tpl_q;
  assign tboth     = tbo_q;

  // R5: an unmask-set write leaves the written bits unmasked
  a_r5_unmask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == IDX_W'(REG_UNMASK)) |=> ((mask_q & $past(wdata)) == '0));

  // R5: a mask-set write leaves the written bits masked
  a_r5_setmask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == IDX_W'(REG_SETMASK)) |=> ((mask_q & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic [NPINS-1:0]  alt_in,
  output logic              irq
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             rst_core_n;
  logic             wr_en, rd_en, clear_all;
  logic [IDX_W-1:0] word;
  logic [NPINS-1:0] level_in, status, handover, dir, oen, oval, mask;
  logic [NPINS-1:0] ttype, tpol, tboth;
  logic             unused_bits;

  assign wr_en       = psel & penable & pwrite;
  assign rd_en       = psel & penable & ~pwrite;
  assign word        = paddr[ADDR_W-1:2];
  assign unused_bits = ^{pwdata, paddr[1:0]};

  gpio_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_core_n)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in (pad_in),
    .sync_out (level_in)
  );

  gpio_regs #(.NPINS(NPINS), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .word      (word),
    .wdata     (pwdata[NPINS-1:0]),
    .rdata     (prdata),
    .in_val    (level_in),
    .status    (status),
    .handover  (handover),
    .dir       (dir),
    .oen       (oen),
    .oval      (oval),
    .mask      (mask),
    .ttype     (ttype),
    .tpol      (tpol),
    .tboth     (tboth),
    .clear_all (clear_all)
  );

  gpio_irq_unit #(.NPINS(NPINS)) u_irq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .level_in  (level_in),
    .ttype     (ttype),
    .tpol      (tpol),
    .tboth     (tboth),
    .clear_all (clear_all),
    .status    (status)
  );

  // pin mux: handover bit selects the alternate path
  assign pad_out = (handover & alt_out) | (~handover & oval);
  assign pad_oe  = (handover & alt_oe) | (~handover & ~dir & oen);
  assign alt_in  = pad_in;
  assign irq     = |(status & ~mask);

  // R10: with nothing pending and unmasked, the request is low
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((status & ~mask) == '0) |-> !irq);

  // R3: a GPIO-owned pin set as input never drives its pad
  a_r3_input_no_drive: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((pad_oe & dir & ~handover) == '0));
endmodule

// File: tb/gpio_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_ctrl_tb;
  localparam int NP = 5;
  localparam logic [31:0] PMASK = 32'h1F;
  localparam logic [7:0] A_HOV = 8'h00, A_DIR = 8'h04, A_OEN = 8'h08, A_OVAL = 8'h0C;
  localparam logic [7:0] A_INV = 8'h10, A_MSK = 8'h14, A_UNM = 8'h18, A_SETM = 8'h1C;
  localparam logic [7:0] A_STAT = 8'h20, A_TTY = 8'h24, A_TPL = 8'h28, A_TBO = 8'h2C;

  logic clk = 1'b0;
  logic rst_n;
  logic psel, penable, pwrite;
  logic [7:0] paddr;
  logic [31:0] pwdata, prdata;
  logic [NP-1:0] pad_in, pad_out, pad_oe, alt_out, alt_oe, alt_in;
  logic irq;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_ctrl #(.NPINS(NP), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe),
    .alt_in(alt_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #0.5 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit lvl_of(bit t, bit v, bit x);
    return t && (x == v);
  endfunction

  function automatic bit edge_of(bit t, bit v, bit a, bit p, bit n);
    if (t) return 1'b0;
    if (a) return p != n;
    return v ? (!p && n) : (p && !n);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] exp_rst [12];
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    pad_in = '0; alt_out = 5'b11001; alt_oe = 5'b00111;
    rst_n = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R11 reset values, R1 map positions
    for (int i = 0; i < 12; i++) exp_rst[i] = 32'h0;
    exp_rst[0] = PMASK; exp_rst[1] = PMASK; exp_rst[5] = PMASK;
    for (int i = 0; i < 12; i++) begin
      rd(8'(i * 4), r);
      chk($sformatf("R11 reset word %0d", i), r, exp_rst[i]);
    end
    chk("R11 irq after reset", {31'b0, irq}, 32'h0);
    chk("R4 pad_oe follows alt after reset", {27'b0, pad_oe}, {27'b0, alt_oe});
    rd(8'h30, r);
    chk("R1 unmapped word reads zero", r, 32'h0);

    // R2 upper bits, R3 readback, R1 byte-lane bits ignored
    wr(A_OVAL, 32'hFFFF_FFEA);
    rd(A_OVAL, r);
    chk("R2 output value upper bits", r, 32'h0A);
    wr(A_TPL | 8'h3, 32'h0000_0015);
    rd(A_TPL, r);
    chk("R1 low address bits ignored", r, 32'h15);
    wr(A_TPL, 32'h0);

    // R5 mask write-one behaviour
    wr(A_UNM, 32'hFFFF_FF05);
    rd(A_MSK, r);
    chk("R5 unmask-set", r, 32'h1A);
    wr(A_UNM, 32'h0);
    rd(A_MSK, r);
    chk("R5 zero write no effect", r, 32'h1A);
    wr(A_SETM, 32'h01);
    rd(A_MSK, r);
    chk("R5 mask-set", r, 32'h1B);
    rd(A_UNM, r);
    chk("R1 write-one word reads zero", r, 32'h0);
    wr(A_SETM, 32'h1F);

    // R6 synchronised input value, R4 alt_in passthrough
    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      pad_in = 5'(v);
      #0.5 chk("R4 alt_in equals pad_in", {27'b0, alt_in}, 32'(v));
      idle(3);
      rd(A_INV, r);
      chk("R6 input value", r, 32'(v));
    end
    pad_in = '0;
    idle(4);
    rd(A_STAT, r);

    // R3/R4 exhaustive handover x direction sweep
    wr(A_OVAL, 32'h16);
    wr(A_OEN, 32'h0D);
    for (int b = 0; b < 32; b++) begin
      for (int d = 0; d < 32; d++) begin
        logic [31:0] eo, ee;
        wr(A_HOV, 32'(b));
        wr(A_DIR, 32'(d));
        eo = ((32'(b) & 32'h19) | (~32'(b) & 32'h16)) & PMASK;
        ee = ((32'(b) & 32'h07) | (~32'(b) & ~32'(d) & 32'h0D)) & PMASK;
        chk("R3/R4 pad_out", {27'b0, pad_out}, eo);
        chk("R3/R4 pad_oe", {27'b0, pad_oe}, ee);
      end
    end
    wr(A_HOV, 32'h0);
    wr(A_DIR, 32'h1F);

    // R7-R10, R12: trigger sweep per pin
    for (int pn = 0; pn < NP; pn++) begin
      for (int md = 0; md < 6; md++) begin
        bit t, v, a;
        t = (md < 2);
        v = (md == 0) || (md == 2) || (md == 4);
        a = (md >= 4);
        for (int p = 0; p < 2; p++) begin
          for (int n = 0; n < 2; n++) begin
            for (int m = 0; m < 2; m++) begin
              bit e, ln;
              wr(A_TTY, 32'(t) << pn);
              wr(A_TPL, 32'(v) << pn);
              wr(A_TBO, 32'(a) << pn);
              wr(A_SETM, 32'h1F);
              wr(A_UNM, m ? 32'h0 : (32'h1 << pn));
              pad_in = 5'(p) << pn;
              idle(5);
              rd(A_STAT, r);
              idle(2);
              pad_in = 5'(n) << pn;
              idle(5);
              ln = lvl_of(t, v, n[0]);
              e = lvl_of(t, v, p[0]) | ln | edge_of(t, v, a, p[0], n[0]);
              chk($sformatf("R10 irq pin%0d mode%0d %0d->%0d m%0d", pn, md, p, n, m),
                  {31'b0, irq}, {31'b0, e & !m});
              rd(A_STAT, r);
              chk($sformatf("R8/R9/R12 status pin%0d mode%0d %0d->%0d m%0d", pn, md, p, n, m),
                  r, 32'(e) << pn);
              rd(A_STAT, r);
              chk($sformatf("R7/R8 after clear pin%0d mode%0d %0d->%0d", pn, md, p, n),
                  r, 32'(ln) << pn);
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule